// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer with a 32-bit register port: a write strobe, a byte address, write data and combinational read data. A single-cycle `tick` input, which pulses at 32 kHz in the target system, paces a 20-bit down-counter. While the watchdog runs, software must write a restart magic word before the counter runs out. When it runs out, the block requests a system reset, raises an interrupt, or does one and then the other, as the control bits select. Control and length writes take effect only when they carry their key pattern, so a stray store cannot stop the watchdog or change its period.

The timeout field counts in units of 512 ticks, so N seconds at 32 kHz is programmed as N×64 (1 to 31 seconds fits the field). The reset request lasts 16 tick periods. An optional external reset pin follows the request, with its active level set by a polarity bit. A software-reset register starts the same pulse at once when it receives its key. Clock generation, bus adapters and the wider reset tree sit outside the block.

Top module: `keyguard_wdt`

## Requirements
- R1: After `rst`, the control word reads 0, the length register reads 0x0000_F800 (unit count 1984 in bits [15:5]), `sys_rst_req` and `irq` are low, and `ext_rst` is high (inactive for the default active-low polarity).
- R2: A write to byte offset 0x00 updates the control bits only when data bits [31:24] are 0x22. Otherwise the control bits are unchanged. The control bits are: bit 0 run, bit 1 external polarity (1 = active high), bit 2 external pin enable, bit 3 interrupt enable, bit 4 auto-start flag, bit 6 two-stage mode. A read returns these bits in the same positions and zero in every other bit.
- R3: A write to offset 0x04 updates the unit count in bits [15:5] only when data bits [4:0] are 0x08. A read returns the count in bits [15:5] and zero elsewhere.
- R4: Writing exactly 0x0000_1971 to offset 0x08 reloads the counter with unit count × 512 ticks. Any other value changes nothing. A new unit count is not used until the next such reload.
- R5: While run is set, the counter drops by one on each tick, and the event fires on the tick that brings it to zero: unit count × 512 ticks after a reload. The counter then reloads from the last reload value. While run is clear, no event fires.
- R6: An expiry event with interrupt enable clear raises `sys_rst_req` in the next cycle. The request stays high through 15 more ticks and falls after the 16th tick.
- R7: An expiry event with interrupt enable set and two-stage mode clear raises only `irq`. `irq` stays high, with no reset request, until a valid restart write clears it.
- R8: In two-stage mode with interrupts enabled, the first expiry raises `irq`. A second expiry with no valid restart in between raises the reset pulse of R6. A valid restart clears the first stage.
- R9: Writing exactly 0x0000_1209 to offset 0x14 raises `sys_rst_req` in the next cycle for the pulse of R6, whether or not run is set. Other values do nothing.
- R10: Outside a reset pulse, `ext_rst` equals the inverse of the polarity bit. During a pulse it equals the polarity bit if the external pin enable is set, and otherwise stays at the inactive level.
- R11: A valid restart write in the same cycle as the tick that would end the count cancels that expiry and reloads the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count enable (32 kHz rate) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| sys_rst_req | output | 1 | Internal reset request pulse |
| ext_rst | output | 1 | External reset pin, polarity programmable |
| irq | output | 1 | Watchdog interrupt, level |

## Verification
Two events can meet in one cycle: a restart write and the tick that would end the count. The bench counts the counter down to its last tick and then drives the restart and that tick together. It judges the result by the absence of a reset request in the following cycle and by a fresh, full-length period measured afterwards. A software-reset write cannot meet a restart write in the same cycle, because both use the one write port. The bench therefore also starts software resets while the counter is idle and checks that the pulse length stays the same.

// File: rtl/keyguard_wdt_pkg.sv
package keyguard_wdt_pkg;

    localparam int          WORD_W      = 32;
    localparam int          OFF_CTRL    = 'h00;
    localparam int          OFF_LEN     = 'h04;
    localparam int          OFF_KICK    = 'h08;
    localparam int          OFF_SWRST   = 'h14;
    localparam logic [7:0]  CTRL_KEY    = 8'h22;
    localparam logic [4:0]  LEN_KEY     = 5'h08;
    localparam int          LEN_LSB     = 5;
    localparam logic [31:0] KICK_MAGIC  = 32'h0000_1971;
    localparam logic [31:0] SWRST_MAGIC = 32'h0000_1209;

    typedef struct packed {
        logic dual;
        logic auto_go;
        logic irq_on;
        logic xrst_on;
        logic xrst_hi;
        logic run;
    } ctrl_t;

    typedef enum logic [1:0] {ACT_NONE, ACT_IRQ, ACT_RST} act_e;

    function automatic ctrl_t ctrl_from_word(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.run     = w[0];
        c.xrst_hi = w[1];
        c.xrst_on = w[2];
        c.irq_on  = w[3];
        c.auto_go = w[4];
        c.dual    = w[6];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w    = '0;
        w[0] = c.run;
        w[1] = c.xrst_hi;
        w[2] = c.xrst_on;
        w[3] = c.irq_on;
        w[4] = c.auto_go;
        w[6] = c.dual;
        return w;
    endfunction

endpackage

// File: rtl/kgw_regs.sv
module kgw_regs
    import keyguard_wdt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LEN_W   = 11,
    parameter int RST_LEN = 1984
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output ctrl_t               ctrl_q,
    output logic [LEN_W-1:0]    len_q,
    output logic                kick_hit,
    output logic                swrst_hit,
    output logic [WORD_W-1:0]   rdata
);
    logic sel_ctrl, sel_len, sel_kick, sel_sw;

    assign sel_ctrl  = wr_en && (addr == ADDR_W'(OFF_CTRL));
    assign sel_len   = wr_en && (addr == ADDR_W'(OFF_LEN));
    assign sel_kick  = wr_en && (addr == ADDR_W'(OFF_KICK));
    assign sel_sw    = wr_en && (addr == ADDR_W'(OFF_SWRST));
    assign kick_hit  = sel_kick && (wdata == KICK_MAGIC);
    assign swrst_hit = sel_sw && (wdata == SWRST_MAGIC);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            len_q  <= LEN_W'(RST_LEN);
        end else begin
            if (sel_ctrl && (wdata[31:24] == CTRL_KEY))
                ctrl_q <= ctrl_from_word(wdata);
            if (sel_len && (wdata[LEN_LSB-1:0] == LEN_KEY))
                len_q <= wdata[LEN_LSB +: LEN_W];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_CTRL))
            rdata = ctrl_to_word(ctrl_q);
        else if (addr == ADDR_W'(OFF_LEN))
            rdata = WORD_W'(len_q) << LEN_LSB;
    end
endmodule

// File: rtl/kgw_count.sv
module kgw_count #(
    parameter int CNT_W     = 20,
    parameter int LEN_W     = 11,
    parameter int UNIT_LOG2 = 9,
    parameter int RST_LEN   = 1984
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             kick_hit,
    input  logic [LEN_W-1:0] len_q,
    output logic             expire
);
    localparam int RLD_W = LEN_W + UNIT_LOG2;
    localparam logic [RLD_W-1:0] RST_RLD = RLD_W'(RST_LEN) << UNIT_LOG2;

    logic [CNT_W-1:0] cnt_q, rld_q, fresh;
    logic             at_end;

    assign fresh  = CNT_W'({len_q, {UNIT_LOG2{1'b0}}});
    assign at_end = (cnt_q < CNT_W'(2));
    assign expire = run && tick && !kick_hit && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            rld_q <= CNT_W'(RST_RLD);
            cnt_q <= CNT_W'(RST_RLD);
        end else if (kick_hit) begin
            rld_q <= fresh;
            cnt_q <= fresh;
        end else if (!run) begin
            cnt_q <= rld_q;
        end else if (tick) begin
            cnt_q <= at_end ? rld_q : cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/kgw_resp.sv
module kgw_resp
    import keyguard_wdt_pkg::*;
#(
    parameter int PULSE_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic expire,
    input  logic kick_hit,
    input  logic swrst_hit,
    input  logic irq_on,
    input  logic dual,
    input  logic xrst_on,
    input  logic xrst_hi,
    output logic sys_rst_req,
    output logic ext_rst,
    output logic irq
);
    localparam int PW = $clog2(PULSE_TICKS + 1);

    logic [PW-1:0] pul_q;
    logic          stage_q, irq_q;
    act_e          act;

    always_comb begin
        act = ACT_NONE;
        if (expire) begin
            if (!irq_on || (dual && stage_q)) act = ACT_RST;
            else                              act = ACT_IRQ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= 1'b0;
            irq_q   <= 1'b0;
            pul_q   <= '0;
        end else begin
            if (kick_hit) begin
                irq_q   <= 1'b0;
                stage_q <= 1'b0;
            end else if (act == ACT_IRQ) begin
                irq_q   <= 1'b1;
                stage_q <= dual;
            end else if (act == ACT_RST) begin
                stage_q <= 1'b0;
            end
            if (swrst_hit || act == ACT_RST)
                pul_q <= PW'(PULSE_TICKS);
            else if (tick && pul_q != '0)
                pul_q <= pul_q - PW'(1);
        end
    end

    assign sys_rst_req = (pul_q != '0);
    assign ext_rst     = (sys_rst_req && xrst_on) ? xrst_hi : !xrst_hi;
    assign irq         = irq_q;
endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
    import keyguard_wdt_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int CNT_W       = 20,
    parameter int LEN_W       = 11,
    parameter int UNIT_LOG2   = 9,
    parameter int PULSE_TICKS = 16,
    parameter int RST_LEN     = 1984
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              sys_rst_req,
    output logic              ext_rst,
    output logic              irq
);
    ctrl_t            ctrl_q;
    logic [LEN_W-1:0] len_q;
    logic             kick_hit, swrst_hit, expire;

    kgw_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RST_LEN(RST_LEN)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ctrl_q(ctrl_q), .len_q(len_q), .kick_hit(kick_hit),
        .swrst_hit(swrst_hit), .rdata(rdata)
    );

    kgw_count #(.CNT_W(CNT_W), .LEN_W(LEN_W), .UNIT_LOG2(UNIT_LOG2),
                .RST_LEN(RST_LEN)) u_count (
        .clk(clk), .rst(rst), .tick(tick), .run(ctrl_q.run),
        .kick_hit(kick_hit), .len_q(len_q), .expire(expire)
    );

    kgw_resp #(.PULSE_TICKS(PULSE_TICKS)) u_resp (
        .clk(clk), .rst(rst), .tick(tick), .expire(expire),
        .kick_hit(kick_hit), .swrst_hit(swrst_hit),
        .irq_on(ctrl_q.irq_on), .dual(ctrl_q.dual),
        .xrst_on(ctrl_q.xrst_on), .xrst_hi(ctrl_q.xrst_hi),
        .sys_rst_req(sys_rst_req), .ext_rst(ext_rst), .irq(irq)
    );
endmodule

// File: rtl/keyguard_wdt_chk.sv
module keyguard_wdt_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [5:0]        ctrl_bits,
    input logic              kick_hit,
    input logic              swrst_hit,
    input logic              sys_rst_req,
    input logic              ext_rst,
    input logic              irq
);
    // R2: a control write with a wrong key leaves the control bits as they were
    p_ctrl_badkey_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(0) && wdata[31:24] != 8'h22) |=> $stable(ctrl_bits));

    // R9: the software reset key starts the pulse in the next cycle
    p_swrst_now_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'('h14) && wdata == 32'h0000_1209) |=> sys_rst_req);

    // R6: a reset request only starts after an expiring tick or a software reset
    p_rst_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_req) |-> ($past(swrst_hit) || ($past(tick) && $past(ctrl_bits[0]))));

    // R6: the pulse cannot shrink in a cycle without a tick
    p_pulse_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (sys_rst_req && !tick) |=> sys_rst_req);

    // R7: a valid restart clears the interrupt
    p_kick_clears_irq_r7: assert property (@(posedge clk) disable iff (rst)
        kick_hit |=> !irq);

    // R7: the interrupt only rises when it is enabled
    p_irq_enabled_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ctrl_bits[3]);

    // R10: idle level of the external pin follows the polarity bit
    p_ext_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !sys_rst_req |-> (ext_rst == !ctrl_bits[1]));

    // R10: with the pin disabled, a pulse leaves it inactive
    p_ext_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (sys_rst_req && !ctrl_bits[2]) |-> (ext_rst == !ctrl_bits[1]));

    // R11: a restart cycle never launches a reset pulse
    p_kick_wins_r11: assert property (@(posedge clk) disable iff (rst)
        kick_hit |=> !$rose(sys_rst_req));
endmodule

bind keyguard_wdt keyguard_wdt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .ctrl_bits(ctrl_q), .kick_hit(kick_hit),
    .swrst_hit(swrst_hit), .sys_rst_req(sys_rst_req), .ext_rst(ext_rst),
    .irq(irq)
);

// File: tb/keyguard_wdt_tb.sv
`timescale 1ns/1ps
module keyguard_wdt_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sys_rst_req, ext_rst, irq;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    localparam int UNIT = 512;
    localparam int PULSE = 16;

    keyguard_wdt dut_i (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sys_rst_req(sys_rst_req),
        .ext_rst(ext_rst), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic t);
        tick = t;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic t);
        addr = a; wdata = d; wr_en = 1'b1;
        cyc(t);
        wr_en = 1'b0; wdata = '0; addr = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
        addr = '0;
    endtask

    task automatic pulse_runs(input string tag, input logic ext_exp);
        for (int i = 1; i < PULSE; i++) begin
            cyc(1'b1);
            chk({tag, " pulse held"}, sys_rst_req, 1'b1);
        end
        chk({tag, " ext pin in pulse"}, ext_rst, ext_exp);
        cyc(1'b1);
        chk({tag, " pulse ends"}, sys_rst_req, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 rst_req", sys_rst_req, 1'b0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 ext idle high", ext_rst, 1'b1);
        rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h04, v); chk("R1 len", v, 32'(1984) << 5);

        // R2: layout and key byte
        wr(8'h00, 32'h22FF_FFFF, 1'b0);
        rd(8'h00, v); chk("R2 layout", v, 32'h0000_005F);
        wr(8'h00, 32'h2100_0000, 1'b0);
        rd(8'h00, v); chk("R2 bad key kept", v, 32'h0000_005F);
        wr(8'h00, 32'h2200_0000, 1'b0);
        for (int k = 0; k < 256; k++) begin
            wr(8'h00, {k[7:0], 24'h00_0010}, 1'b0);
            rd(8'h00, v);
            chk("R2 key sweep", v, (k == 'h22) ? 32'h10 : 32'h0);
            wr(8'h00, 32'h2200_0000, 1'b0);
        end

        // R3: length key sweep and field position
        wr(8'h04, 32'h0000_0028, 1'b0);
        for (int k = 0; k < 32; k++) begin
            wr(8'h04, (32'd3 << 5) | 32'(k), 1'b0);
            rd(8'h04, v);
            chk("R3 key sweep", v, (k == 8) ? 32'h60 : 32'h20);
            wr(8'h04, 32'h0000_0028, 1'b0);
        end
        wr(8'h04, 32'hFFFF_FFE8, 1'b0);
        rd(8'h04, v); chk("R3 full field", v, 32'h0000_FFE0);
        wr(8'h04, 32'h0000_0028, 1'b0);

        // R5: stopped counter never fires
        wr(8'h08, 32'h0000_1971, 1'b0);
        ticks(2000);
        chk("R5 stopped no reset", sys_rst_req, 1'b0);
        chk("R5 stopped no irq", irq, 1'b0);

        // R5 / R6: period of one unit, pulse length, pin active low
        wr(8'h08, 32'h0000_1971, 1'b0);
        wr(8'h00, 32'h2200_0005, 1'b0);
        ticks(UNIT - 1);
        chk("R5 before end", sys_rst_req, 1'b0);
        cyc(1'b1);
        chk("R5 at end", sys_rst_req, 1'b1);
        chk("R10 ext active low", ext_rst, 1'b0);
        pulse_runs("R6", 1'b0);
        chk("R10 ext back idle", ext_rst, 1'b1);

        // R4: new length used only after reload; wrong magic ignored
        wr(8'h08, 32'h0000_1971, 1'b0);
        wr(8'h04, (32'd2 << 5) | 32'h8, 1'b0);
        ticks(UNIT - 1);
        chk("R4 old length kept", sys_rst_req, 1'b0);
        cyc(1'b1);
        chk("R4 old length end", sys_rst_req, 1'b1);
        pulse_runs("R4a", 1'b0);
        wr(8'h08, 32'h0000_1971, 1'b0);
        ticks(2 * UNIT - 1);
        chk("R4 new length before", sys_rst_req, 1'b0);
        cyc(1'b1);
        chk("R4 new length end", sys_rst_req, 1'b1);
        pulse_runs("R4b", 1'b0);
        wr(8'h08, 32'h0000_1971, 1'b0);
        ticks(1000);
        wr(8'h08, 32'h0000_1970, 1'b0);
        ticks(2 * UNIT - 1000 - 1);
        chk("R4 bad magic before", sys_rst_req, 1'b0);
        cyc(1'b1);
        chk("R4 bad magic no reload", sys_rst_req, 1'b1);
        pulse_runs("R4c", 1'b0);

        // R11: restart on the expiring tick wins
        wr(8'h04, 32'h0000_0028, 1'b0);
        wr(8'h08, 32'h0000_1971, 1'b0);
        ticks(UNIT - 1);
        wr(8'h08, 32'h0000_1971, 1'b1);
        chk("R11 no reset", sys_rst_req, 1'b0);
        ticks(UNIT - 1);
        chk("R11 fresh period before", sys_rst_req, 1'b0);
        cyc(1'b1);
        chk("R11 fresh period end", sys_rst_req, 1'b1);
        pulse_runs("R11", 1'b0);

        // R7: interrupt only
        wr(8'h00, 32'h2200_000D, 1'b0);
        wr(8'h08, 32'h0000_1971, 1'b0);
        ticks(UNIT - 1);
        chk("R7 irq before", irq, 1'b0);
        cyc(1'b1);
        chk("R7 irq raised", irq, 1'b1);
        chk("R7 no reset", sys_rst_req, 1'b0);
        seen = 0;
        for (int i = 0; i < 600; i++) begin
            cyc(1'b1);
            if (sys_rst_req || !irq) seen++;
        end
        chk("R7 irq held no reset", seen, 0);
        wr(8'h08, 32'h0000_1971, 1'b0);
        chk("R7 restart clears irq", irq, 1'b0);

        // R8: two-stage mode
        wr(8'h00, 32'h2200_0049, 1'b0);
        wr(8'h08, 32'h0000_1971, 1'b0);
        ticks(UNIT);
        chk("R8 first stage irq", irq, 1'b1);
        chk("R8 first stage no reset", sys_rst_req, 1'b0);
        ticks(UNIT - 1);
        chk("R8 second before", sys_rst_req, 1'b0);
        cyc(1'b1);
        chk("R8 second stage reset", sys_rst_req, 1'b1);
        pulse_runs("R8", 1'b1);
        wr(8'h08, 32'h0000_1971, 1'b0);
        ticks(UNIT);
        chk("R8 restart then irq", irq, 1'b1);
        chk("R8 restart then no reset", sys_rst_req, 1'b0);
        wr(8'h08, 32'h0000_1971, 1'b0);
        ticks(UNIT);
        chk("R8 stage cleared by restart", sys_rst_req, 1'b0);
        wr(8'h08, 32'h0000_1971, 1'b0);

        // R9: software reset while stopped
        wr(8'h00, 32'h2200_0000, 1'b0);
        wr(8'h14, 32'h0000_1208, 1'b0);
        chk("R9 wrong key", sys_rst_req, 1'b0);
        wr(8'h14, 32'h0000_1209, 1'b0);
        chk("R9 immediate", sys_rst_req, 1'b1);
        pulse_runs("R9", 1'b1);

        // R10: polarity and pin enable
        wr(8'h00, 32'h2200_0002, 1'b0);
        chk("R10 idle active-high pin", ext_rst, 1'b0);
        wr(8'h14, 32'h0000_1209, 1'b0);
        chk("R10 disabled pin quiet", ext_rst, 1'b0);
        pulse_runs("R10a", 1'b0);
        wr(8'h00, 32'h2200_0006, 1'b0);
        wr(8'h14, 32'h0000_1209, 1'b0);
        chk("R10 pin driven high", ext_rst, 1'b1);
        pulse_runs("R10b", 1'b1);
        chk("R10 pin idle after", ext_rst, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule